// File: doc/BRIEF.md
# Audio Output Interrupt and Status Controller

This block is the control and status register logic for an audio output unit. The unit drains two DMA buffers in turn. A small register port lets software set a transmit enable, a low-power override and four interrupt enables. The same port is used to read back four event flags and a capture register.

The datapath sends single-cycle pulses to the block:
- buffer 1 ran empty;
- buffer 2 ran empty;
- a memory bandwidth error occurred;
- an output underrun occurred;
- the last sample of a buffer has left the serial pin.

The first four pulses set sticky flags. Software clears each flag by writing a one to its acknowledge bit. The flags that are enabled are combined into one registered interrupt line. A free-running cycle counter is latched on the last-sample pulse, so software can see when the final sample of the most recent buffer went out.

Top module: `aout_irq_ctrl`

## Requirements
- R1: After reset, the following are all 0: tx_en, keep_awake, the four interrupt enables, the four flags, irq, wake_req, the timestamp and the cycle counter.
- R2: A write to address 0 loads tx_en from bit 0, keep_awake from bit 1 and the four interrupt enables from bits 2..5. The enables are, in order, buffer 1 empty, buffer 2 empty, bandwidth error and underrun. A read of address 0 returns these six bits in the same positions, with all other bits 0. tx_en and keep_awake drive the output ports of the same name.
- R3: A pulse on an event input sets its flag on the next clock edge. Address 1 reads the flags in bits 0..3: buffer 1 empty, buffer 2 empty, bandwidth error, underrun. A flag, the bandwidth-error flag included, stays set until its acknowledge bit is written.
- R4: A write to address 0 with bits 8..11 set clears the matching flags, in the same order as R3. Writing 0 to an acknowledge bit has no effect. Acknowledge bits always read as 0.
- R5: irq is registered. In each cycle it equals the OR of (flag AND enable) as they stood in the previous cycle.
- R6: If an event pulse and its acknowledge fall in the same cycle, the flag ends up set.
- R7: The cycle counter starts at 0 after reset and increments on every clock edge. On a last-sample pulse, address 2 captures the counter value of that cycle and holds it until the next pulse.
- R8: A read of address 3 returns 0.
- R9: wake_req equals irq AND keep_awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| ev_buf1_empty | input | 1 | Buffer 1 empty pulse |
| ev_buf2_empty | input | 1 | Buffer 2 empty pulse |
| ev_bw_err | input | 1 | Bandwidth error pulse |
| ev_underrun | input | 1 | Underrun pulse |
| ev_last_out | input | 1 | Last sample of a buffer left the pin |
| tx_en | output | 1 | Transmit enable |
| keep_awake | output | 1 | Keep running in global power-down |
| irq | output | 1 | Registered interrupt request |
| wake_req | output | 1 | Wake-up request while in power-down |

## Verification
The case that needs care is an event pulse arriving in the same cycle as a write that acknowledges that flag. A directed sequence forces this collision on every flag, including the sticky bandwidth-error flag, and then reads the status register to confirm the set won. Random stimulus then overlaps writes carrying acknowledge bits with event pulses and last-sample pulses. A behavioural model updated on every edge judges the results, through the readback of each address and through irq and wake_req.

// File: rtl/aout_irq_ctrl.sv
module aout_irq_ctrl #(
  parameter int TS_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ev_buf1_empty,
  input  logic        ev_buf2_empty,
  input  logic        ev_bw_err,
  input  logic        ev_underrun,
  input  logic        ev_last_out,
  output logic        tx_en,
  output logic        keep_awake,
  output logic        irq,
  output logic        wake_req
);
  logic [3:0]      en_r;
  logic [3:0]      flags;
  logic [TS_W-1:0] cnt;
  logic [TS_W-1:0] ts;
  logic [3:0]      evt;
  logic [3:0]      ack;
  logic            ctl_wr;

  assign evt    = {ev_underrun, ev_bw_err, ev_buf2_empty, ev_buf1_empty};
  assign ctl_wr = wr_en && (addr == 2'd0);
  assign ack    = ctl_wr ? wdata[11:8] : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en      <= 1'b0;
      keep_awake <= 1'b0;
      en_r       <= '0;
      flags      <= '0;
      irq        <= 1'b0;
      cnt        <= '0;
      ts         <= '0;
    end else begin
      if (ctl_wr) begin
        tx_en      <= wdata[0];
        keep_awake <= wdata[1];
        en_r       <= wdata[5:2];
      end
      flags <= (flags & ~ack) | evt;
      irq   <= |(flags & en_r);
      cnt   <= cnt + 1'b1;
      if (ev_last_out) ts <= cnt;
    end
  end

  assign wake_req = irq & keep_awake;

  always_comb begin
    case (addr)
      2'd0:    rdata = {26'd0, en_r, keep_awake, tx_en};
      2'd1:    rdata = {28'd0, flags};
      2'd2:    rdata = 32'(ts);
      default: rdata = 32'd0;
    endcase
  end
endmodule

module aout_irq_ctrl_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [31:0]     wdata,
  input logic [3:0]      evt,
  input logic [3:0]      flags,
  input logic [3:0]      en_r,
  input logic            irq,
  input logic            ev_last_out,
  input logic [TS_W-1:0] cnt,
  input logic [TS_W-1:0] ts
);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[8] && !evt[0]) |=> !flags[0]);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[2] |=> flags[2]);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !(wr_en && addr == 2'd0 && wdata[10])) |=> flags[2]);
  assert_irq_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & en_r)) |=> irq);
  assert_ts_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_out |=> ts == $past(cnt));
  assert_cnt_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt != $past(cnt));
endmodule

bind aout_irq_ctrl aout_irq_ctrl_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .evt(evt), .flags(flags), .en_r(en_r), .irq(irq),
  .ev_last_out(ev_last_out), .cnt(cnt), .ts(ts)
);

// File: tb/sim_aout_irq_ctrl.sv
`timescale 1ns/1ps
module sim_aout_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic        e1 = 1'b0, e2 = 1'b0, eb = 1'b0, eu = 1'b0, el = 1'b0;
  logic [31:0] rdata;
  logic        tx_en, keep_awake, irq, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit [3:0]  m_en, m_fl;
  bit        m_tx, m_keep, m_irq;
  bit [31:0] m_cnt, m_ts;

  always #2.5 clk = ~clk;

  aout_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_buf1_empty(e1), .ev_buf2_empty(e2), .ev_bw_err(eb),
    .ev_underrun(eu), .ev_last_out(el), .tx_en(tx_en),
    .keep_awake(keep_awake), .irq(irq), .wake_req(wake_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_fl = 0; m_tx = 0; m_keep = 0; m_irq = 0; m_cnt = 0; m_ts = 0;
    end else begin
      bit [3:0] fl_old, en_old;
      fl_old = m_fl; en_old = m_en;
      m_irq = (fl_old & en_old) != 0;
      if (wr_en && addr == 0) begin
        m_fl = m_fl & ~wdata[11:8];
        m_tx = wdata[0]; m_keep = wdata[1]; m_en = wdata[5:2];
      end
      m_fl = m_fl | {eu, eb, e2, e1};
      if (el) m_ts = m_cnt;
      m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {26'd0, m_en, m_keep, m_tx};
      2'd1: return {28'd0, m_fl};
      2'd2: return m_ts;
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare();
    chk("R2 tx_en", tx_en, m_tx);
    chk("R2 keep_awake", keep_awake, m_keep);
    chk("R5 irq", irq, m_irq);
    chk("R9 wake_req", wake_req, m_irq & m_keep);
    case (addr)
      2'd0: chk("R2/R4 ctrl read", rdata, m_read(addr));
      2'd1: chk("R3 status read", rdata, m_read(addr));
      2'd2: chk("R7 timestamp read", rdata, m_read(addr));
      default: chk("R8 unmapped read", rdata, m_read(addr));
    endcase
  endtask

  task automatic step(bit w, logic [1:0] a, logic [31:0] d, logic [4:0] ev);
    wr_en = w; addr = a; wdata = d;
    {el, eu, eb, e2, e1} = ev;
    @(negedge clk);
    compare();
  endtask

  task automatic rd(logic [1:0] a);
    step(0, a, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(negedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog expired");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 wake_req", wake_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 0; #0.1 chk("R1 ctrl", rdata, 0);
    addr = 1; #0.1 chk("R1 flags", rdata, 0);
    addr = 2; #0.1 chk("R1 ts", rdata, 0);

    // R2 enables and control readback
    step(1, 0, 32'h0000_003F, 0);
    rd(0);
    // R3 set each flag, sticky
    step(0, 1, 0, 5'b00001);
    step(0, 1, 0, 5'b00100);
    rd(1); rd(1);
    chk("R3 bw sticky", rdata, 32'h5);
    // R4 writing 0 acks: no effect; ack bits read 0
    step(1, 0, 32'h0000_003F, 0);
    rd(1);
    chk("R4 zero ack no effect", rdata, 32'h5);
    rd(0);
    chk("R4 ack reads zero", rdata[11:8], 0);
    // R4 clear bandwidth error only
    step(1, 0, 32'h0000_043F, 0);
    rd(1);
    chk("R4 clear bw", rdata, 32'h1);
    // R6 set wins on every flag
    step(1, 0, 32'h0000_0F3F, 5'b01111);
    rd(1);
    chk("R6 set wins", rdata, 32'hF);
    // R7 timestamp capture
    step(0, 2, 0, 5'b10000);
    rd(2); rd(2);
    // R9 keep_awake off then on
    step(1, 0, 32'h0000_003D, 0);
    rd(0);
    step(1, 0, 32'h0000_0F3F, 0);
    rd(1); rd(1);

    for (int i = 0; i < 3000; i++) begin
      bit w;
      w = ($urandom_range(0, 3) == 0);
      step(w, 2'($urandom_range(0, 3)), $urandom,
           {($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 9) == 0)});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule